// File: doc/BRIEF.md
# Interrupt Channel Priority Router

This block sits after the per-source enable logic of an interrupt controller. It takes a vector of up to 64 pending, already-enabled sources. A programmable map assigns each source to one of 32 priority channels. A second map steers each channel to one of two host request lines: a fast line and a normal line.

For each host line the block selects one winning source from the channels steered to that line. A lower channel number has higher priority. When two sources share a channel, the lower source number wins. Each line's winner index, a valid flag and the host request are registered.

Host requests are gated by a global enable and by a per-line enable. Software sets or clears a line enable by writing the line's index to a set register or a clear register. Configuration is written through a simple word-addressed write port.

Top module: `irq_chan_router`

## Requirements
- R1: After reset both winner indices read all ones (63), both valid flags and both requests are 0, every source maps to channel 15, only channels 0 and 1 steer to the fast line, and the global and line enables are 0.
- R2: Map word k, at word address k for k in 0..15, holds the channels of sources 4k..4k+3. Source 4k+j takes its channel from bits [8j+4:8j] of that word. Bits [8j+7:8j+5] are ignored.
- R3: Within one host line, the pending source on the lowest channel number wins.
- R4: Among pending sources on the same channel of a line, the lowest source number wins.
- R5: The steering word sits at address 16. Bit c = 1 steers channel c to the fast line and bit c = 0 steers it to the normal line.
- R6: The fast winner and the normal winner are chosen independently, each only from sources whose channel is steered to its own line.
- R7: When a line has no pending source, its index output reads all ones and its valid flag reads 0.
- R8: The global enable is bit 0 of the word at address 17. While it is 0, neither request is asserted, but winners and valid flags are still reported.
- R9: A write to address 18 sets the enable of the line named by data bit 0, and a write to address 19 clears it. Line index 0 is fast and 1 is normal. A line's request is 1 exactly when its valid flag is 1, the global enable is 1 and the line enable is 1.
- R10: Outputs change on the first rising edge after the pending input changes and hold until then. A configuration write takes effect on the outputs at the second rising edge after the write is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Configuration write strobe |
| regAddr | input | 5 | Configuration word address |
| regWrData | input | 32 | Configuration write data |
| pending | input | 64 | Enabled-and-pending source vector |
| fastIdx | output | 6 | Winning source index on the fast line |
| fastValid | output | 1 | A fast-line source is pending |
| fastReq | output | 1 | Fast host request |
| normIdx | output | 6 | Winning source index on the normal line |
| normValid | output | 1 | A normal-line source is pending |
| normReq | output | 1 | Normal host request |

## Verification
A change on the pending vector shows up on every output one rising edge later. The bench drives the vector at a falling edge and samples at the next falling edge. Before that edge it also confirms the old values still hold.

A configuration write is driven for one cycle starting at a falling edge. The register captures it on the next rising edge, and the outputs reflect it on the rising edge after that. The bench therefore waits one more full cycle before it samples.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Decoded configuration write strobes, control -> datapath
  typedef struct packed {
    logic mapWr;
    logic hostMapWr;
    logic globWr;
    logic hostSet;
    logic hostClr;
  } regStrobe_t;

  localparam int HOST_FAST = 0;
  localparam int HOST_NORM = 1;
  localparam int NUM_HOST  = 2;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_MAP   = 16,
  parameter int ADDR_W    = 5,
  parameter int MAP_SEL_W = 4
) (
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  output regStrobe_t           strobe,
  output logic [MAP_SEL_W-1:0] mapSel
);

  localparam logic [ADDR_W-1:0] A_HOSTMAP = ADDR_W'(NUM_MAP);
  localparam logic [ADDR_W-1:0] A_GLOB    = ADDR_W'(NUM_MAP + 1);
  localparam logic [ADDR_W-1:0] A_SET     = ADDR_W'(NUM_MAP + 2);
  localparam logic [ADDR_W-1:0] A_CLR     = ADDR_W'(NUM_MAP + 3);

  always_comb begin
    strobe           = '0;
    strobe.mapWr     = regWrEn && (regAddr < A_HOSTMAP);
    strobe.hostMapWr = regWrEn && (regAddr == A_HOSTMAP);
    strobe.globWr    = regWrEn && (regAddr == A_GLOB);
    strobe.hostSet   = regWrEn && (regAddr == A_SET);
    strobe.hostClr   = regWrEn && (regAddr == A_CLR);
  end

  assign mapSel = regAddr[MAP_SEL_W-1:0];

endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb #(
  parameter int NUM_SRC = 64,
  parameter int CHAN_W  = 5,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [CHAN_W-1:0]  chanOf [NUM_SRC],
  input  logic [NUM_SRC-1:0] inGroup,
  input  logic               reqAllow,
  output logic [IDX_W-1:0]   winIdx,
  output logic               winValid,
  output logic               winReq
);

  logic              found;
  logic [CHAN_W-1:0] bestChan;
  logic [IDX_W-1:0]  bestIdx;

  // Ascending scan with strict compare: lower channel wins, ties keep the lower source
  always_comb begin
    found    = 1'b0;
    bestChan = '0;
    bestIdx  = '1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pending[s] && inGroup[s] && (!found || chanOf[s] < bestChan)) begin
        found    = 1'b1;
        bestChan = chanOf[s];
        bestIdx  = IDX_W'(s);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winIdx   <= '1;
      winValid <= 1'b0;
      winReq   <= 1'b0;
    end else begin
      winIdx   <= found ? bestIdx : '1;
      winValid <= found;
      winReq   <= found && reqAllow;
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int          NUM_SRC       = 64,
  parameter int          NUM_CHAN      = 32,
  parameter int          CHAN_W        = 5,
  parameter int          IDX_W         = 6,
  parameter int          MAP_SEL_W     = 4,
  parameter int          MAP_RST_CHAN  = 15,
  parameter logic [31:0] FAST_MASK_RST = 32'h3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [MAP_SEL_W-1:0] mapSel,
  input  logic [31:0]          regWrData,
  input  logic [NUM_SRC-1:0]   pending,
  output logic [IDX_W-1:0]     winIdx   [NUM_HOST],
  output logic                 winValid [NUM_HOST],
  output logic                 winReq   [NUM_HOST]
);

  localparam int SRC_PER_WORD = 4;
  localparam int LANE_W       = 8;

  logic [CHAN_W-1:0]   chanQ [NUM_SRC];
  logic [NUM_CHAN-1:0] hostMapQ;
  logic                globQ;
  logic [NUM_HOST-1:0] hostEnQ;
  logic [NUM_SRC-1:0]  inFast;

  // Per-source channel storage, byte lane j of word k feeds source 4k+j
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        chanQ[s] <= CHAN_W'(MAP_RST_CHAN);
      else if (strobe.mapWr && mapSel == MAP_SEL_W'(s / SRC_PER_WORD))
        chanQ[s] <= regWrData[LANE_W*(s % SRC_PER_WORD) +: CHAN_W];
    end
    assign inFast[s] = hostMapQ[chanQ[s]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostMapQ <= FAST_MASK_RST[NUM_CHAN-1:0];
      globQ    <= 1'b0;
      hostEnQ  <= '0;
    end else begin
      if (strobe.hostMapWr) hostMapQ <= regWrData[NUM_CHAN-1:0];
      if (strobe.globWr)    globQ    <= regWrData[0];
      if (strobe.hostSet)   hostEnQ[regWrData[0]] <= 1'b1;
      if (strobe.hostClr)   hostEnQ[regWrData[0]] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_HOST; g++) begin : g_host
    logic [NUM_SRC-1:0] grp;
    if (g == HOST_FAST) begin : g_fast
      assign grp = inFast;
    end else begin : g_norm
      assign grp = ~inFast;
    end

    irq_router_arb #(
      .NUM_SRC(NUM_SRC),
      .CHAN_W (CHAN_W),
      .IDX_W  (IDX_W)
    ) u_arb (
      .clk     (clk),
      .rstN    (rstN),
      .pending (pending),
      .chanOf  (chanQ),
      .inGroup (grp),
      .reqAllow(globQ && hostEnQ[g]),
      .winIdx  (winIdx[g]),
      .winValid(winValid[g]),
      .winReq  (winReq[g])
    );
  end

endmodule

// File: rtl/irq_chan_router.sv
module irq_chan_router
  import irq_router_pkg::*;
#(
  parameter int          NUM_SRC       = 64,
  parameter int          NUM_CHAN      = 32,
  parameter int          MAP_RST_CHAN  = 15,
  parameter logic [31:0] FAST_MASK_RST = 32'h3,
  localparam int IDX_W     = $clog2(NUM_SRC),
  localparam int CHAN_W    = $clog2(NUM_CHAN),
  localparam int NUM_MAP   = (NUM_SRC + 3) / 4,
  localparam int ADDR_W    = $clog2(NUM_MAP + 4),
  localparam int MAP_SEL_W = (NUM_MAP > 1) ? $clog2(NUM_MAP) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  input  logic [NUM_SRC-1:0] pending,
  output logic [IDX_W-1:0]   fastIdx,
  output logic               fastValid,
  output logic               fastReq,
  output logic [IDX_W-1:0]   normIdx,
  output logic               normValid,
  output logic               normReq
);

  regStrobe_t           strobe;
  logic [MAP_SEL_W-1:0] mapSel;
  logic [IDX_W-1:0]     winIdx   [NUM_HOST];
  logic                 winValid [NUM_HOST];
  logic                 winReq   [NUM_HOST];

  irq_router_ctrl #(
    .NUM_MAP  (NUM_MAP),
    .ADDR_W   (ADDR_W),
    .MAP_SEL_W(MAP_SEL_W)
  ) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe),
    .mapSel (mapSel)
  );

  irq_router_dp #(
    .NUM_SRC      (NUM_SRC),
    .NUM_CHAN     (NUM_CHAN),
    .CHAN_W       (CHAN_W),
    .IDX_W        (IDX_W),
    .MAP_SEL_W    (MAP_SEL_W),
    .MAP_RST_CHAN (MAP_RST_CHAN),
    .FAST_MASK_RST(FAST_MASK_RST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mapSel   (mapSel),
    .regWrData(regWrData),
    .pending  (pending),
    .winIdx   (winIdx),
    .winValid (winValid),
    .winReq   (winReq)
  );

  assign fastIdx   = winIdx[HOST_FAST];
  assign fastValid = winValid[HOST_FAST];
  assign fastReq   = winReq[HOST_FAST];
  assign normIdx   = winIdx[HOST_NORM];
  assign normValid = winValid[HOST_NORM];
  assign normReq   = winReq[HOST_NORM];

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] pending,
  input logic [IDX_W-1:0]   fastIdx,
  input logic               fastValid,
  input logic               fastReq,
  input logic [IDX_W-1:0]   normIdx,
  input logic               normValid,
  input logic               normReq
);

  logic [NUM_SRC-1:0] pendQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pending;
  end

  p_fast_idx_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    !fastValid |-> fastIdx == '1);
  p_norm_idx_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    !normValid |-> normIdx == '1);
  p_idle_no_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == '0) |-> (!fastValid && !normValid));
  p_fast_win_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    fastValid |-> pendQ[fastIdx]);
  p_norm_win_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    normValid |-> pendQ[normIdx]);
  p_fast_req_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    fastReq |-> fastValid);
  p_norm_req_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    normReq |-> normValid);
  p_groups_disjoint_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fastValid && normValid) |-> fastIdx != normIdx);

endmodule

bind irq_chan_router irq_router_chk #(
  .NUM_SRC(NUM_SRC),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pending  (pending),
  .fastIdx  (fastIdx),
  .fastValid(fastValid),
  .fastReq  (fastReq),
  .normIdx  (normIdx),
  .normValid(normValid),
  .normReq  (normReq)
);

// File: tb/irq_chan_router_test.sv
`timescale 1ns/1ps
module irq_chan_router_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [63:0] pending = '0;
  logic [5:0]  fastIdx, normIdx;
  logic        fastValid, normValid, fastReq, normReq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_chan_router uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pending(pending),
    .fastIdx(fastIdx), .fastValid(fastValid), .fastReq(fastReq),
    .normIdx(normIdx), .normValid(normValid), .normReq(normReq)
  );

  // Table: pending, expected fast {valid,idx}, expected normal {valid,idx}
  // Map programmed before the walk: src2->ch1, src5->ch0, src9->ch0 (fast),
  // src63->ch2 (byte 0xE2), src20->ch31, all others ch15 (normal).
  localparam int NT = 9;
  localparam logic [63:0] T_PEND [NT] = '{
    64'h0, 64'h4, 64'h204, 64'h220, 64'h8000_0000_0010_0000,
    64'h4010_0000, 64'h8000_0000_0000_0005, 64'h10_0000, 64'h3 };
  localparam logic [6:0] T_FAST [NT] = '{
    {1'b0,6'd63}, {1'b1,6'd2}, {1'b1,6'd9}, {1'b1,6'd5}, {1'b0,6'd63},
    {1'b0,6'd63}, {1'b1,6'd2}, {1'b0,6'd63}, {1'b0,6'd63} };
  localparam logic [6:0] T_NORM [NT] = '{
    {1'b0,6'd63}, {1'b0,6'd63}, {1'b0,6'd63}, {1'b0,6'd63}, {1'b1,6'd63},
    {1'b1,6'd30}, {1'b1,6'd63}, {1'b1,6'd20}, {1'b1,6'd0} };

  task automatic checkOut(input string tag, input logic [6:0] expF,
                          input logic [6:0] expN, input logic expFr,
                          input logic expNr);
    logic [8:0] act, exp;
    act = {fastValid, fastIdx, fastReq, normReq};
    exp = {expF, expFr, expNr};
    checks++;
    if (act != exp || {normValid, normIdx} != expN) begin
      errors++;
      $display("FAIL %s: actual fast=%0d/v%0d req f%0d n%0d norm=%0d/v%0d, expected fast=%0d/v%0d req f%0d n%0d norm=%0d/v%0d",
               tag, fastIdx, fastValid, fastReq, normReq, normIdx, normValid,
               expF[5:0], expF[6], expFr, expNr, expN[5:0], expN[6]);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic applyPend(input logic [63:0] v);
    @(negedge clk);
    pending = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOut("R1 reset", {1'b0,6'd63}, {1'b0,6'd63}, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: default map puts every source on ch15, steered to normal
    applyPend(64'h0000_0100_0000_0080);
    checkOut("R1 R4 default map", {1'b0,6'd63}, {1'b1,6'd7}, 1'b0, 1'b0);

    // R2: program map words
    regWrite(5'd0,  32'h0F01_0F0F);
    regWrite(5'd1,  32'h0F0F_000F);
    regWrite(5'd2,  32'h0F0F_000F);
    regWrite(5'd5,  32'h0F0F_0F1F);
    regWrite(5'd15, 32'hE20F_0F0F);

    for (int i = 0; i < NT; i++) begin
      applyPend(T_PEND[i]);
      checkOut($sformatf("R2 R3 R4 R6 R7 table %0d", i), T_FAST[i], T_NORM[i], 1'b0, 1'b0);
    end

    // R9: enable global and fast line only
    regWrite(5'd17, 32'h1);
    regWrite(5'd18, 32'h0);
    applyPend(64'h8000_0000_0000_0004);
    checkOut("R9 fast enabled", {1'b1,6'd2}, {1'b1,6'd63}, 1'b1, 1'b0);
    regWrite(5'd18, 32'h1);
    checkOut("R9 both enabled", {1'b1,6'd2}, {1'b1,6'd63}, 1'b1, 1'b1);
    regWrite(5'd19, 32'h0);
    checkOut("R9 fast cleared", {1'b1,6'd2}, {1'b1,6'd63}, 1'b0, 1'b1);
    // R8: global off masks requests, winners remain
    regWrite(5'd17, 32'h0);
    checkOut("R8 global off", {1'b1,6'd2}, {1'b1,6'd63}, 1'b0, 1'b0);
    regWrite(5'd17, 32'h1);
    // R5: steer only ch2 to fast
    regWrite(5'd16, 32'h4);
    checkOut("R5 R6 steering", {1'b1,6'd63}, {1'b1,6'd2}, 1'b0, 1'b1);

    // R10: one-cycle latency, hold until the edge
    @(negedge clk);
    pending = 64'h0;
    #1;
    checkOut("R10 hold before edge", {1'b1,6'd63}, {1'b1,6'd2}, 1'b0, 1'b1);
    @(negedge clk);
    checkOut("R10 R7 after edge", {1'b0,6'd63}, {1'b0,6'd63}, 1'b0, 1'b0);

    // R10: write latency, host map write seen only at the second edge
    pending = 64'h4;
    @(negedge clk);
    checkOut("R10 before write", {1'b0,6'd63}, {1'b1,6'd2}, 1'b0, 1'b1);
    regWrEn = 1'b1; regAddr = 5'd16; regWrData = 32'h2;
    @(negedge clk);
    regWrEn = 1'b0;
    checkOut("R10 write one edge", {1'b0,6'd63}, {1'b1,6'd2}, 1'b0, 1'b1);
    @(negedge clk);
    checkOut("R10 R5 write two edges", {1'b1,6'd2}, {1'b0,6'd63}, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule